// File: doc/BRIEF.md
# Glitch-Free Clock Generator Slice

This block builds one output clock from a set of input clocks. A small set of primary clocks feeds a glitch-free multiplexer. The highest primary slot is not a pin: it carries the output of an auxiliary selector, which picks one of seven further clocks by a 3-bit code. Control software chooses the primary slot, the auxiliary code, a run enable and a hard kill. It reads back a one-hot status word that shows which primary slot is actually reaching the output.

A handover between primary slots is not instant. The old slot is gated off on its own falling edge, and only then is the new slot gated on at its falling edge. While this happens the status word drops to all zeros, so software polls it until the new bit shows. The auxiliary selector is a plain combinational pick. Its code should only change while the output is stopped. The run enable starts and stops the output on whole clock phases. The kill forces the output low at once, with no clock involved. A build option removes the glitch-free multiplexer. That build drives the output from the auxiliary selector only, and its status word is fixed at 1.

Top module: `gfcs_slice`

## Requirements
- R1: With run enabled, `src_sel` value i (0 = `prim_clk[0]`, 1 = `prim_clk[1]`, 2 = auxiliary selector output) makes `clk_out` run at the period of that source once the handover has settled.
- R2: `selected` never has more than one bit set. Bit i (same numbering as R1) is set only while source i drives the output, and the word may read zero during a handover.
- R3: After reset is released, `selected` reads 3'b001 and, with `enable` low, `clk_out` is low.
- R4: Outside a kill, no high or low phase of `clk_out` is shorter than half the period of the fastest input clock, across source switches and across enable changes.
- R5: With `enable` low, `clk_out` is held low within three cycles of the selected clock. Raising `enable` starts it again.
- R6: `kill` high forces `clk_out` low with no clock edge needed. After `kill` falls, the output stays low until the enable has been resynchronized, and then it resumes.
- R7: `aux_sel` codes 0 to 6 route `aux_clk[code]` into primary slot 2.
- R8: `aux_sel` code 7 is reserved. It holds the auxiliary feed low, so the output stops while slot 2 is selected, and a later valid code restores it.
- R9: `src_sel` value 3 selects no source. `selected` goes to zero and `clk_out` stays low.
- R10: When built without the glitch-free multiplexer, the output follows the auxiliary selector, `selected` is fixed at 3'b001 and `src_sel` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled synchronously in each clock domain |
| prim_clk | input | NUM_PRIM | Primary clock pins, slots 0 to NUM_PRIM-1 |
| aux_clk | input | NUM_AUX | Candidate clocks for the auxiliary selector |
| src_sel | input | SEL_W | Requested primary slot |
| aux_sel | input | 3 | Auxiliary code, 0 to 6 valid, 7 reserved |
| enable | input | 1 | Clean run enable |
| kill | input | 1 | Asynchronous stop |
| clk_out | output | 1 | Generated clock |
| selected | output | NUM_SRC | One-hot slot now driving the output, zero in handover |

## Verification
A handover takes up to three periods of the old clock to gate it off, then up to three periods of the new clock to gate that one on. An enable change takes up to three periods of the selected clock. The kill acts within the same time step. After each change the bench therefore waits 400 ns before its scoreboard monitor measures a 300 ns window. In that window it counts rising edges, takes the period between the last two, and reads `selected` at the end. The kill is checked 1 ns after each of its edges. A phase monitor and a status monitor run for the whole test and are judged at the end.

// File: rtl/gfcs_pkg.sv
// Shared constants for the clock generator slice.
// Assumes the auxiliary code is three bits wide and code 7 is reserved.
package gfcs_pkg;
    localparam int AUX_SEL_W    = 3;
    localparam int AUX_CODE_MAX = 7;
    typedef logic [AUX_SEL_W-1:0] aux_code_t;
endpackage

// File: rtl/gfcs_aux_pick.sv
// Auxiliary source picker: combinational choice of one auxiliary clock.
// Assumes the code only changes while the output is stopped, because a
// change can glitch. Codes at or above NUM_AUX give a constant low.
module gfcs_aux_pick
    import gfcs_pkg::*;
#(
    parameter int NUM_AUX = 7
) (
    input  logic [NUM_AUX-1:0] aux_clk,
    input  aux_code_t          code,
    output logic               clk_o
);
    // Pick the matching clock. An unmatched code falls through to low.
    always_comb begin
        clk_o = 1'b0;
        for (int k = 0; k < NUM_AUX; k++) begin
            if (code == AUX_SEL_W'(k)) clk_o = aux_clk[k];
        end
    end
endmodule

// File: rtl/gfcs_src_cell.sv
// One source cell of the glitch-free multiplexer.
// The request is synchronized on rising edges of the cell's own clock. The
// output gate only changes on falling edges, so the gated clock is cut or
// passed while it is low. Assumes the reset is held for several cycles of
// this clock.
module gfcs_src_cell #(
    parameter bit START_ON    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic gate_o
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Bring the request into this clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{START_ON}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], want};
    end

    // Update the gate while the clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n) gate_o <= START_ON;
        else        gate_o <= sync_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/gfcs_glitchless_mux.sv
// Cross-coupled glitch-free clock multiplexer.
// A cell asks to turn on only while every other gate is off, so the old clock
// is cut before the new one is passed. The status word is the vector of
// gates. Assumes the select is not changed again before a handover ends, and
// that the clock being left is still running.
module gfcs_glitchless_mux #(
    parameter int NUM_SRC     = 3,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic [NUM_SRC-1:0] clks,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    output logic               mclk,
    output logic [NUM_SRC-1:0] status
);
    logic [NUM_SRC-1:0] gate;
    logic [NUM_SRC-1:0] want;
    logic [NUM_SRC-1:0] path;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [NUM_SRC-1:0] OTHERS = ~(NUM_SRC'(1) << i);

        // Request slot i only once all other slots are off.
        assign want[i] = (sel == SEL_W'(i)) && ((gate & OTHERS) == '0);

        gfcs_src_cell #(
            .START_ON    (i == 0),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cell (
            .clk    (clks[i]),
            .rst_n  (rst_n),
            .want   (want[i]),
            .gate_o (gate[i])
        );

        assign path[i] = clks[i] & gate[i];
    end

    assign mclk   = |path;
    assign status = gate;
endmodule

// File: rtl/gfcs_run_gate.sv
// Output gate with a clean enable and an asynchronous kill.
// The enable is synchronized on the muxed clock and applied on its falling
// edge. The kill clears the synchronizer and the gate at once and also masks
// the output directly. Assumes the muxed clock runs when the enable must act.
module gfcs_run_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kill,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] en_q;
    logic                   en_gate;

    // Bring the enable into the muxed clock domain. The kill clears it at once.
    always_ff @(posedge clk or posedge kill) begin
        if (kill)        en_q <= '0;
        else if (!rst_n) en_q <= '0;
        else             en_q <= {en_q[SYNC_STAGES-2:0], enable};
    end

    // Open or close the gate while the clock is low.
    always_ff @(negedge clk or posedge kill) begin
        if (kill)        en_gate <= 1'b0;
        else if (!rst_n) en_gate <= 1'b0;
        else             en_gate <= en_q[SYNC_STAGES-1];
    end

    assign clk_o = clk & en_gate & ~kill;
endmodule

// File: rtl/gfcs_slice.sv
// Clock generator slice top.
// The auxiliary picker feeds the highest primary slot. A glitch-free mux
// (or, when HAS_GLITCHLESS is 0, a direct wire from the auxiliary picker)
// drives the run gate. Assumes every clock that takes part in a handover is
// running and that reset is held for several cycles of each clock.
module gfcs_slice
    import gfcs_pkg::*;
#(
    parameter int NUM_PRIM       = 2,
    parameter int NUM_AUX        = 7,
    parameter int SYNC_STAGES    = 2,
    parameter bit HAS_GLITCHLESS = 1'b1,
    localparam int NUM_SRC       = NUM_PRIM + 1,
    localparam int SEL_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 rst_n,
    input  logic [NUM_PRIM-1:0]  prim_clk,
    input  logic [NUM_AUX-1:0]   aux_clk,
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [AUX_SEL_W-1:0] aux_sel,
    input  logic                 enable,
    input  logic                 kill,
    output logic                 clk_out,
    output logic [NUM_SRC-1:0]   selected
);
    logic aux_feed;
    logic mux_clk;

    gfcs_aux_pick #(.NUM_AUX(NUM_AUX)) u_aux (
        .aux_clk (aux_clk),
        .code    (aux_sel),
        .clk_o   (aux_feed)
    );

    if (HAS_GLITCHLESS) begin : g_mux
        logic [NUM_SRC-1:0] clk_vec;
        assign clk_vec = {aux_feed, prim_clk};

        gfcs_glitchless_mux #(
            .NUM_SRC     (NUM_SRC),
            .SEL_W       (SEL_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_mux (
            .clks   (clk_vec),
            .rst_n  (rst_n),
            .sel    (src_sel),
            .mclk   (mux_clk),
            .status (selected)
        );
    end else begin : g_direct
        logic unused_inputs;
        assign unused_inputs = ^{prim_clk, src_sel};
        assign mux_clk       = aux_feed;
        assign selected      = NUM_SRC'(1);
    end

    gfcs_run_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk    (mux_clk),
        .rst_n  (rst_n),
        .enable (enable),
        .kill   (kill),
        .clk_o  (clk_out)
    );
endmodule

// File: rtl/gfcs_slice_chk.sv
// Property checker for gfcs_slice, attached by bind.
// Clocked by primary clock 0. Windows longer than one cycle are tracked with
// saturating counters.
module gfcs_slice_chk #(
    parameter int NUM_SRC        = 3,
    parameter int SEL_W          = 2,
    parameter bit HAS_GLITCHLESS = 1'b1
) (
    input logic               chk_clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   src_sel,
    input logic               enable,
    input logic               kill,
    input logic               clk_out,
    input logic [NUM_SRC-1:0] selected
);
    logic [3:0] idle_cnt;
    logic [3:0] bad_cnt;

    // Count checker cycles with the enable low.
    always_ff @(posedge chk_clk) begin
        if (!rst_n || enable)   idle_cnt <= '0;
        else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 4'd1;
    end

    // Count checker cycles with an out-of-range source select.
    always_ff @(posedge chk_clk) begin
        if (!rst_n || (int'(src_sel) < NUM_SRC)) bad_cnt <= '0;
        else if (bad_cnt != 4'hF)                bad_cnt <= bad_cnt + 4'd1;
    end

    p_onehot_status_r2: assert property (@(posedge chk_clk) disable iff (!rst_n)
        $onehot0(selected));

    p_reset_status_r3: assert property (@(posedge chk_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (selected == NUM_SRC'(1)));

    p_stop_on_disable_r5: assert property (@(posedge chk_clk) disable iff (!rst_n)
        (idle_cnt >= 4'd12) |-> !clk_out);

    p_kill_holds_low_r6: assert property (@(posedge chk_clk) disable iff (!rst_n)
        $past(kill) |-> !clk_out);

    if (HAS_GLITCHLESS) begin : g_mux_props
        p_no_source_r9: assert property (@(posedge chk_clk) disable iff (!rst_n)
            (bad_cnt >= 4'd12) |-> (selected == '0));
    end else begin : g_direct_props
        logic unused_cnt;
        assign unused_cnt = ^bad_cnt;
        p_fixed_status_r10: assert property (@(posedge chk_clk) disable iff (!rst_n)
            selected == NUM_SRC'(1));
    end
endmodule

bind gfcs_slice gfcs_slice_chk #(
    .NUM_SRC        (NUM_SRC),
    .SEL_W          (SEL_W),
    .HAS_GLITCHLESS (HAS_GLITCHLESS)
) u_chk (
    .chk_clk  (prim_clk[0]),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .enable   (enable),
    .kill     (kill),
    .clk_out  (clk_out),
    .selected (selected)
);

// File: tb/sim_gfcs_slice.sv
`timescale 1ns/100ps
module sim_gfcs_slice;
    typedef struct {
        string tag;
        int    dut;
        int    exp_sel;
        int    exp_per;
    } item_t;

    logic       rst_n = 1'b0;
    logic [1:0] prim_clk;
    logic [6:0] aux_clk;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] aux_sel = 3'd0;
    logic       enable = 1'b0;
    logic       kill = 1'b0;
    logic       clk_out0, clk_out1;
    logic [2:0] sel0, sel1;

    int    checks = 0, errors = 0, done_cnt = 0;
    int    glitches = 0, bad_onehot = 0;
    bit    kill_guard = 1'b0, finished = 1'b0;
    item_t q[$];

    // Primary clock 0 is the 50 MHz bench clock; primary 1 has a 14 ns period.
    logic c0 = 1'b0, c1 = 1'b0;
    initial forever #10 c0 = ~c0;
    initial forever #7  c1 = ~c1;
    assign prim_clk = {c1, c0};

    // Auxiliary clock k has a period of 16 + 4k ns.
    for (genvar k = 0; k < 7; k++) begin : g_aux
        logic c = 1'b0;
        initial forever #(8 + 2 * k) c = ~c;
        assign aux_clk[k] = c;
    end

    gfcs_slice u0 (
        .rst_n(rst_n), .prim_clk(prim_clk), .aux_clk(aux_clk), .src_sel(src_sel),
        .aux_sel(aux_sel), .enable(enable), .kill(kill),
        .clk_out(clk_out0), .selected(sel0)
    );

    gfcs_slice #(.HAS_GLITCHLESS(1'b0)) u1 (
        .rst_n(rst_n), .prim_clk(prim_clk), .aux_clk(aux_clk), .src_sel(src_sel),
        .aux_sel(aux_sel), .enable(enable), .kill(kill),
        .clk_out(clk_out1), .selected(sel1)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: let the last change settle, then queue an expected item and wait.
    task automatic expect_item(input string tag, input int dut, input int es, input int ep);
        int target;
        #400;
        @(negedge c0);
        #0.5;
        target = done_cnt + 1;
        q.push_back('{tag, dut, es, ep});
        wait (done_cnt >= target);
    endtask

    // Monitor: pop each item, measure a 300 ns window, compare.
    initial begin
        forever begin
            item_t it;
            logic  prv, cur;
            real   tprev, tlast;
            int    nedge, per;
            wait (q.size() > 0);
            it = q.pop_front();
            nedge = 0; tprev = 0.0; tlast = 0.0;
            prv = (it.dut == 0) ? clk_out0 : clk_out1;
            for (int s = 0; s < 300; s++) begin
                #1;
                cur = (it.dut == 0) ? clk_out0 : clk_out1;
                if (cur && !prv) begin
                    nedge++;
                    tprev = tlast;
                    tlast = $realtime;
                end
                prv = cur;
            end
            per = (nedge >= 2) ? int'(tlast - tprev) : 0;
            check(per == it.exp_per, it.tag, "period_ns", per, it.exp_per);
            check(int'((it.dut == 0) ? sel0 : sel1) == it.exp_sel, it.tag, "selected",
                  int'((it.dut == 0) ? sel0 : sel1), it.exp_sel);
            done_cnt++;
        end
    end

    // R4 phase monitor: each phase of u0's output must last at least 7 ns.
    real last_edge = 0.0;
    bit  seen_edge = 1'b0;
    always @(clk_out0) begin
        if (seen_edge && !kill_guard && ($realtime - last_edge) < 7.0) glitches++;
        last_edge = $realtime;
        seen_edge = 1'b1;
    end

    // R2 status monitor: checked at every falling edge of the bench clock.
    always @(negedge c0) if (rst_n && !$onehot0(sel0)) bad_onehot++;

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200;
        @(negedge c0);
        rst_n = 1'b1;
        #1;
        check(sel0 == 3'b001, "R3", "selected_after_reset", int'(sel0), 1);
        check(clk_out0 == 1'b0, "R3", "clk_out_after_reset", int'(clk_out0), 0);
        expect_item("R5 disabled", 0, 1, 0);

        enable = 1'b1;
        expect_item("R1 R5 prim0", 0, 1, 20);
        src_sel = 2'd1;
        expect_item("R1 prim1", 0, 2, 14);
        src_sel = 2'd2;
        expect_item("R7 aux0", 0, 4, 16);

        enable = 1'b0;
        expect_item("R5 stop on aux", 0, 4, 0);
        aux_sel = 3'd3;
        #50;
        enable = 1'b1;
        expect_item("R7 aux3", 0, 4, 28);

        enable = 1'b0;
        #300;
        aux_sel = 3'd7;
        #50;
        enable = 1'b1;
        expect_item("R8 reserved code", 0, 4, 0);
        enable = 1'b0;
        #100;
        aux_sel = 3'd1;
        #300;
        enable = 1'b1;
        expect_item("R8 R7 recover aux1", 0, 4, 20);

        src_sel = 2'd3;
        expect_item("R9 no source", 0, 0, 0);
        src_sel = 2'd0;
        expect_item("R1 back to prim0", 0, 1, 20);

        // R6: kill acts at once, holds, then the output resumes after resync.
        @(posedge c0);
        #3;
        kill_guard = 1'b1;
        kill = 1'b1;
        #1;
        check(clk_out0 == 1'b0, "R6", "low_right_after_kill", int'(clk_out0), 0);
        expect_item("R6 killed", 0, 1, 0);
        @(posedge c0);
        #3;
        kill = 1'b0;
        #1;
        check(clk_out0 == 1'b0, "R6", "low_right_after_release", int'(clk_out0), 0);
        #100;
        kill_guard = 1'b0;
        expect_item("R6 resumed", 0, 1, 20);

        // R10: the variant follows the auxiliary picker and ignores src_sel.
        enable = 1'b0;
        #300;
        aux_sel = 3'd3;
        #50;
        enable = 1'b1;
        expect_item("R10 variant aux3", 1, 1, 28);
        src_sel = 2'd1;
        expect_item("R10 variant ignores select", 1, 1, 28);
        expect_item("R1 prim1 again", 0, 2, 14);

        check(glitches == 0, "R4", "short_phases", glitches, 0);
        check(bad_onehot == 0, "R2", "status_not_onehot0", bad_onehot, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule